// File: doc/BRIEF.md
# Full-Frame CCD Readout Clock Sequencer

The block produces the transfer clocks that read a full-frame CCD out line by line. It does this with three nested counters running from the master clock. A phase tick advances every clock. A line slot advances each time the phase tick wraps. A vertical step index advances on tick wraps during the first few slots of each line.

Each line has two segments. In the leading slots a line reference level is high, and the four vertical clocks step once through a six-step overlapping sequence that shifts one row into the output register. In the remaining slots the reference is low, and the three horizontal clocks cycle through a six-step overlapping pattern that moves pixels to the output amplifier. The transfer gate follows vertical phase 1, and the summing and reset gates follow horizontal phase 3. With a 150 MHz master clock and a tick modulus of six, the horizontal clocks run at 25 MHz.

An exposure sequencer raises `enable` to start a readout. When the configured number of lines has been sent, the block raises `done` for one cycle and then stays quiet until `enable` is removed.

The controller has five named states:
- IDLE: waits for `enable`.
- VERT: the vertical segment of a line.
- HORZ: the horizontal segment of a line.
- FINISH: the one-cycle done state.
- HALT: waits for `enable` to drop.

The transitions are:
- IDLE→VERT when `enable` rises.
- VERT→HORZ when the last vertical slot ends.
- HORZ→VERT at the end of a line that is not the last.
- HORZ→FINISH at the end of the last line.
- FINISH→HALT unconditionally.
- Any state→IDLE when `enable` is low.

Top module: `ccd_readout_timer`

## Requirements
- R1: While `rst_n` is low, and after reset until `enable` is sampled high, every output is 0.
- R2: Outputs are registered. Call the clock edge that first samples `enable` high edge c. After edge c+1+j, the outputs show line time j, where tick = j mod TICK_MOD, slot = (j / TICK_MOD) mod SLOT_MOD and line = j / (TICK_MOD·SLOT_MOD).
- R3: `line_ref` is 1 in slots below H_START and 0 in slots from H_START to SLOT_MOD-1.
- R4: `v_clk` bits [3:0] are phases 4,3,2,1. In slots 0..5 it shows, per slot, 1110, 0110, 0111, 0011, 1011, 1111. In every later slot of the line it shows the rest pattern 1110.
- R5: While running, successive nonzero `v_clk` values differ in at most one bit, and a nonzero `v_clk` has at least two bits set.
- R6: `h_clk` bits [2:0] are phases 3,2,1. It is 000 in slots below H_START. From H_START onward it shows, for tick 0..5, the values 001, 011, 010, 110, 100, 101.
- R7: `xfer_gate` equals `v_clk[0]`, and `sum_gate` and `rst_gate` both equal `h_clk[2]`.
- R8: After ROWS lines, `done` is 1 for exactly one cycle, after edge c+ROWS·TICK_MOD·SLOT_MOD+1. All other outputs are 0 then. The block then stays idle with no new readout while `enable` remains high.
- R9: If `enable` is sampled low, all outputs are 0 after the next edge. Raising `enable` again restarts the readout from line 0, slot 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Readout enable from the exposure sequencer |
| line_ref | output | 1 | High during vertical transfer, low during horizontal transfer |
| v_clk | output | 4 | Vertical phases 4..1 |
| xfer_gate | output | 1 | Transfer gate, follows vertical phase 1 |
| h_clk | output | 3 | Horizontal phases 3..1 |
| sum_gate | output | 1 | Summing gate, follows horizontal phase 3 |
| rst_gate | output | 1 | Output reset gate, follows horizontal phase 3 |
| done | output | 1 | One-cycle pulse after the last line |

## Verification
A full three-line readout is compared cycle by cycle against a model written from R2–R7. The comparison separates:
- the one-cycle output latency;
- the slot at which the horizontal clocks begin;
- the vertical step order;
- the wrap from one line to the next.

Table points pin the corner cycles:
- the last vertical slot before the threshold;
- the first horizontal slot;
- the last tick of a line;
- the start of the second line.

Directed runs then check three things: the single done pulse and the halt that follows it while `enable` stays high, dropping `enable` mid-line followed by a restart from slot 0, and reset applied during a readout.

// File: rtl/ccd_rdo_pkg.sv
package ccd_rdo_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_VERT,
        ST_HORZ,
        ST_FINISH,
        ST_HALT
    } rdo_state_e;

    localparam logic [3:0] V_REST = 4'b1110;

    // Vertical phases {4,3,2,1}; one bit changes per step, cyclic back to rest.
    function automatic logic [3:0] vert_step(input int idx);
        logic [3:0] v;
        case (idx)
            0:       v = 4'b1110;
            1:       v = 4'b0110;
            2:       v = 4'b0111;
            3:       v = 4'b0011;
            4:       v = 4'b1011;
            5:       v = 4'b1111;
            default: v = V_REST;
        endcase
        return v;
    endfunction

    // Horizontal phases {3,2,1}; one bit changes per tick, cyclic.
    function automatic logic [2:0] horz_step(input int idx);
        logic [2:0] h;
        case (idx)
            0:       h = 3'b001;
            1:       h = 3'b011;
            2:       h = 3'b010;
            3:       h = 3'b110;
            4:       h = 3'b100;
            5:       h = 3'b101;
            default: h = 3'b000;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/ccd_tick_chain.sv
module ccd_tick_chain #(
    parameter int TICK_MOD = 6,
    parameter int SLOT_MOD = 4764,
    parameter int STEP_MOD = 6,
    parameter int H_START  = 683,
    parameter int ROWS     = 5356,
    localparam int TW = (TICK_MOD > 1) ? $clog2(TICK_MOD) : 1,
    localparam int LW = (SLOT_MOD > 1) ? $clog2(SLOT_MOD) : 1,
    localparam int SW = (STEP_MOD > 1) ? $clog2(STEP_MOD) : 1,
    localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    output logic [TW-1:0] tick,
    output logic [LW-1:0] slot,
    output logic [SW-1:0] step,
    output logic          vert_end,
    output logic          line_end,
    output logic          last_row
);

    localparam logic [TW-1:0] TICK_LAST = TW'(TICK_MOD - 1);
    localparam logic [LW-1:0] SLOT_LAST = LW'(SLOT_MOD - 1);
    localparam logic [LW-1:0] VERT_LAST = LW'(H_START - 1);
    localparam logic [LW-1:0] STEP_SPAN = LW'(STEP_MOD);
    localparam logic [SW-1:0] STEP_LAST = SW'(STEP_MOD - 1);
    localparam logic [RW-1:0] ROW_LAST  = RW'(ROWS - 1);

    logic [RW-1:0] row;
    logic          tick_wrap;

    assign tick_wrap = (tick == TICK_LAST);
    assign vert_end  = tick_wrap && (slot == VERT_LAST);
    assign line_end  = tick_wrap && (slot == SLOT_LAST);
    assign last_row  = (row == ROW_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick <= '0;
            slot <= '0;
            step <= '0;
            row  <= '0;
        end else if (!run) begin
            tick <= '0;
            slot <= '0;
            step <= '0;
            row  <= '0;
        end else begin
            tick <= tick_wrap ? '0 : tick + 1'b1;
            if (tick_wrap)
                slot <= (slot == SLOT_LAST) ? '0 : slot + 1'b1;
            if (tick_wrap && (slot < STEP_SPAN))
                step <= (step == STEP_LAST) ? '0 : step + 1'b1;
            if (line_end)
                row <= last_row ? '0 : row + 1'b1;
        end
    end

    a_r8_row_bound: assert property (@(posedge clk) disable iff (!rst_n)
        row <= ROW_LAST);

    a_r2_step_rest_after_seq: assert property (@(posedge clk) disable iff (!rst_n)
        (run && slot >= STEP_SPAN) |-> step == '0);

endmodule

// File: rtl/ccd_phase_fsm.sv
module ccd_phase_fsm
    import ccd_rdo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       vert_end,
    input  logic       line_end,
    input  logic       last_row,
    output rdo_state_e state,
    output logic       run
);

    rdo_state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (enable) state_nx = ST_VERT;
            ST_VERT:   if (!enable) state_nx = ST_IDLE;
                       else if (vert_end) state_nx = ST_HORZ;
            ST_HORZ:   if (!enable) state_nx = ST_IDLE;
                       else if (line_end) state_nx = last_row ? ST_FINISH : ST_VERT;
            ST_FINISH: state_nx = enable ? ST_HALT : ST_IDLE;
            ST_HALT:   if (!enable) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    assign run = (state == ST_VERT) || (state == ST_HORZ);

    a_r8_finish_once: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FINISH) |=> (state != ST_FINISH));

endmodule

// File: rtl/ccd_wave_gen.sv
module ccd_wave_gen
    import ccd_rdo_pkg::*;
#(
    parameter int TW = 3,
    parameter int SW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  rdo_state_e    state,
    input  logic [TW-1:0] tick,
    input  logic [SW-1:0] step,
    output logic          ref_q,
    output logic [3:0]    v_q,
    output logic [2:0]    h_q,
    output logic          done_q
);

    logic       ref_n;
    logic [3:0] v_n;
    logic [2:0] h_n;
    logic       done_n;

    always_comb begin
        ref_n  = 1'b0;
        v_n    = '0;
        h_n    = '0;
        done_n = 1'b0;
        if (enable) begin
            unique case (state)
                ST_VERT: begin
                    ref_n = 1'b1;
                    v_n   = vert_step(int'(step));
                end
                ST_HORZ: begin
                    v_n = V_REST;
                    h_n = horz_step(int'(tick));
                end
                ST_FINISH: done_n = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q  <= 1'b0;
            v_q    <= '0;
            h_q    <= '0;
            done_q <= 1'b0;
        end else begin
            ref_q  <= ref_n;
            v_q    <= v_n;
            h_q    <= h_n;
            done_q <= done_n;
        end
    end

endmodule

// File: rtl/ccd_readout_timer.sv
module ccd_readout_timer
    import ccd_rdo_pkg::*;
#(
    parameter int TICK_MOD = 6,
    parameter int SLOT_MOD = 4764,
    parameter int STEP_MOD = 6,
    parameter int H_START  = 683,
    parameter int ROWS     = 5356
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    output logic       line_ref,
    output logic [3:0] v_clk,
    output logic       xfer_gate,
    output logic [2:0] h_clk,
    output logic       sum_gate,
    output logic       rst_gate,
    output logic       done
);

    localparam int TW = (TICK_MOD > 1) ? $clog2(TICK_MOD) : 1;
    localparam int LW = (SLOT_MOD > 1) ? $clog2(SLOT_MOD) : 1;
    localparam int SW = (STEP_MOD > 1) ? $clog2(STEP_MOD) : 1;
    localparam logic [LW-1:0] H_FIRST = LW'(H_START);

    logic [TW-1:0] tick;
    logic [LW-1:0] slot;
    logic [SW-1:0] step;
    logic          vert_end, line_end, last_row, run;
    rdo_state_e    state;

    ccd_tick_chain #(
        .TICK_MOD(TICK_MOD), .SLOT_MOD(SLOT_MOD), .STEP_MOD(STEP_MOD),
        .H_START(H_START), .ROWS(ROWS)
    ) u_chain (
        .clk(clk), .rst_n(rst_n), .run(run),
        .tick(tick), .slot(slot), .step(step),
        .vert_end(vert_end), .line_end(line_end), .last_row(last_row)
    );

    ccd_phase_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .vert_end(vert_end), .line_end(line_end), .last_row(last_row),
        .state(state), .run(run)
    );

    ccd_wave_gen #(.TW(TW), .SW(SW)) u_wave (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .state(state), .tick(tick), .step(step),
        .ref_q(line_ref), .v_q(v_clk), .h_q(h_clk), .done_q(done)
    );

    assign xfer_gate = v_clk[0];
    assign sum_gate  = h_clk[2];
    assign rst_gate  = h_clk[2];

    a_r6_horz_past_threshold: assert property (@(posedge clk) disable iff (!rst_n)
        (h_clk != 3'b000) |-> ($past(slot) >= H_FIRST && $past(state) == ST_HORZ));

    a_r6_horz_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (h_clk != 3'b000 && $past(h_clk) != 3'b000)
            |-> $countones(h_clk ^ $past(h_clk)) <= 1);

    a_r5_vert_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (v_clk != 4'b0000 && $past(v_clk) != 4'b0000)
            |-> $countones(v_clk ^ $past(v_clk)) <= 1);

    a_r5_vert_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        (v_clk != 4'b0000) |-> $countones(v_clk) >= 2);

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_enable_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (v_clk == 4'b0000 && h_clk == 3'b000 && !done && !line_ref));

endmodule

// File: tb/ccd_readout_timer_tb.sv
module ccd_readout_timer_tb;

    localparam int T = 6;
    localparam int L = 20;
    localparam int HS = 8;
    localparam int NR = 3;
    localparam int N = T * L * NR;
    localparam int NV = 13;

    // {line_ref, v_clk[3:0], h_clk[2:0]} at chosen line times
    localparam int VJ [NV] = '{0, 6, 13, 35, 36, 47, 48, 49, 51, 53, 119, 120, 126};
    localparam logic [7:0] VEXP [NV] = '{
        8'b1_1110_000, 8'b1_0110_000, 8'b1_0111_000, 8'b1_1111_000,
        8'b1_1110_000, 8'b1_1110_000, 8'b0_1110_001, 8'b0_1110_011,
        8'b0_1110_110, 8'b0_1110_101, 8'b0_1110_101, 8'b1_1110_000,
        8'b1_0110_000};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic line_ref, xfer_gate, sum_gate, rst_gate, done;
    logic [3:0] v_clk;
    logic [2:0] h_clk;

    int n_vec = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    always #2.5 clk = ~clk;

    ccd_readout_timer #(
        .TICK_MOD(T), .SLOT_MOD(L), .STEP_MOD(6), .H_START(HS), .ROWS(NR)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .line_ref(line_ref), .v_clk(v_clk), .xfer_gate(xfer_gate),
        .h_clk(h_clk), .sum_gate(sum_gate), .rst_gate(rst_gate), .done(done)
    );

    function automatic logic [7:0] model(input int j);
        int t = j % T;
        int p = (j / T) % L;
        logic [3:0] v;
        logic [2:0] h;
        if (p < HS) begin
            case (p)
                0: v = 4'b1110; 1: v = 4'b0110; 2: v = 4'b0111;
                3: v = 4'b0011; 4: v = 4'b1011; 5: v = 4'b1111;
                default: v = 4'b1110;
            endcase
            return {1'b1, v, 3'b000};
        end
        case (t)
            0: h = 3'b001; 1: h = 3'b011; 2: h = 3'b010;
            3: h = 3'b110; 4: h = 3'b100; default: h = 3'b101;
        endcase
        return {1'b0, 4'b1110, h};
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_idle(input string tag);
        check(tag, {line_ref, v_clk, h_clk}, 8'h00);
        check(tag, {5'b0, xfer_gate, sum_gate, rst_gate}, 8'h00);
        check(tag, {7'b0, done}, 8'h00);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic start_run();
        enable = 1'b1;
        @(posedge clk);
    endtask

    task automatic finish_bench();
        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #50000;
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_bench();
    end

    initial begin
        int vi;
        // R1: reset state
        #12;
        @(negedge clk);
        check_idle("R1 in reset");
        rst_n = 1'b1;
        step();
        step();
        check_idle("R1 after reset, enable low");

        // Full readout: table walk plus per-cycle model (R2..R7)
        start_run();
        vi = 0;
        for (int j = 0; j < N; j++) begin
            step();
            check("R2/R3/R4/R6 model", {line_ref, v_clk, h_clk}, model(j));
            check("R7 gates", {5'b0, xfer_gate, sum_gate, rst_gate},
                  {5'b0, v_clk[0], h_clk[2], h_clk[2]});
            check("R8 no early done", {7'b0, done}, 8'h00);
            if (vi < NV && VJ[vi] == j) begin
                check($sformatf("R4/R6 table j=%0d", j), {line_ref, v_clk, h_clk}, VEXP[vi]);
                vi++;
            end
        end

        // R8: single done pulse, then halt while enable held
        step();
        check("R8 done pulse", {7'b0, done}, 8'h01);
        check("R8 idle at done", {line_ref, v_clk, h_clk}, 8'h00);
        step();
        check_idle("R8 after done");
        for (int k = 0; k < 10; k++) begin
            step();
            check_idle("R8 halt with enable high");
        end

        // R9: drop mid-line then restart from slot 0
        enable = 1'b0;
        step();
        start_run();
        for (int j = 0; j <= 50; j++) step();
        check("R9 running before drop", {line_ref, v_clk, h_clk}, model(50));
        enable = 1'b0;
        step();
        check_idle("R9 idle after enable low");
        start_run();
        for (int j = 0; j < 8 * T; j++) begin
            step();
            check("R9 restart from slot 0", {line_ref, v_clk, h_clk}, model(j));
        end

        // R1: reset during readout
        rst_n = 1'b0;
        #1;
        check_idle("R1 reset mid-run");
        enable = 1'b0;
        step();
        rst_n = 1'b1;
        step();
        check_idle("R1 idle after mid-run reset");

        finish_bench();
    end

endmodule